// File: doc/BRIEF.md
# Watchdog Interval Timer with Status Register

An 8-bit up-counter with one control/status register. The counter is clocked by a prescaled tick taken from a free-running system-clock divider. On overflow it either issues a single-cycle reset request (watchdog mode) or raises an interrupt level (interval mode). Software reaches the block through a small synchronous register port. Address 0 holds the control/status register and address 1 holds the counter.

Both registers are guarded against stray stores. A write lands only when it is a 16-bit access whose upper byte matches a per-register key: 0xA5 for the control/status register and 0x5A for the counter. The lower byte carries the value. The overflow flag follows a read-then-clear discipline. A software-standby input clears the mode, enable and flag bits and leaves the clock-select field as it was.

Top module: `wdt_timer`

## Requirements
- R1: After reset, address 0 reads 0x18, address 1 reads 0x00, and both `reset_req` and `irq` are low.
- R2: A write to address 0 takes effect only when `bus_wide`=1 and `bus_wdata[15:8]`=0xA5. A byte write (`bus_wide`=0) or a wrong key leaves the register unchanged. Fields: bit 6 is mode (1 = watchdog, 0 = interval), bit 5 is enable, and bits 2:0 are clock select.
- R3: Bits 4 and 3 of address 0 always read as 1.
- R4: A write to address 1 loads `bus_wdata[7:0]` into the counter only when `bus_wide`=1 and `bus_wdata[15:8]`=0x5A. Any other write to address 1 leaves the counter unchanged.
- R5: While enabled, the counter steps once every 2^k system clocks. Clock-select codes 0 to 7 give k = 1, 5, 6, 7, 8, 9, 11, 12.
- R6: While the enable bit is 0, the counter holds at 0x00. Clearing the enable bit therefore clears the counter.
- R7: A step from 0xFF to 0x00 sets bit 7 (overflow flag), whatever the mode.
- R8: Bit 7 clears only when a key-valid write with bit 7 = 0 follows a read of address 0 made while bit 7 was 1. Writing 1 to bit 7 has no effect. Writing 0 to bit 7 without that earlier read also has no effect.
- R9: In interval mode, `irq` is high exactly while the overflow flag is set, and `reset_req` stays low.
- R10: In watchdog mode, an overflow produces a `reset_req` pulse exactly one cycle wide, and `irq` stays low.
- R11: A `standby` cycle clears bits 7 to 5, keeps bits 2:0, and thereby returns the counter to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Software-standby entry |
| bus_addr | input | 1 | Register select: 0 = control/status, 1 = counter |
| bus_we | input | 1 | Write enable |
| bus_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 8 | Read data of the selected register |
| reset_req | output | 1 | One-cycle reset request on a watchdog overflow |
| irq | output | 1 | Interrupt request level in interval mode |

## Verification
The hardest situation to reach is the flag-clear sequence. A clear write must be preceded by a read taken while the flag is already set, and each failed attempt must leave the flag in place. The stimulus preloads the counter with 0xFD through the counter key at the fastest tick, so an overflow comes within a few cycles. It then issues a clear without a read, a read followed by a write of 1, and finally a read followed by a write of 0, confirming the flag after each step. The rate check counts steps over a window of exactly 320 or 1280 edges, which gives an exact count whatever the prescaler phase.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter logic [7:0] CSR_KEY = 8'hA5,
  parameter logic [7:0] CNT_KEY = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby,
  input  logic        bus_addr,
  input  logic        bus_we,
  input  logic        bus_wide,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        reset_req,
  output logic        irq
);
  localparam int PRE_W = 12;

  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   span;
  logic [7:0]       cnt;
  logic [2:0]       cks;
  logic             ovf, wd, tme, armed, tick, ovf_evt, csr_hit, cnt_hit;

  function automatic logic [3:0] div_shift(input logic [2:0] c);
    case (c)
      3'd0: div_shift = 4'd1;
      3'd1: div_shift = 4'd5;
      3'd2: div_shift = 4'd6;
      3'd3: div_shift = 4'd7;
      3'd4: div_shift = 4'd8;
      3'd5: div_shift = 4'd9;
      3'd6: div_shift = 4'd11;
      default: div_shift = 4'd12;
    endcase
  endfunction

  assign span    = ({{PRE_W{1'b0}}, 1'b1} << div_shift(cks)) - 1'b1;
  assign tick    = (pre & span[PRE_W-1:0]) == span[PRE_W-1:0];
  assign csr_hit = bus_we && bus_wide && !bus_addr && bus_wdata[15:8] == CSR_KEY;
  assign cnt_hit = bus_we && bus_wide &&  bus_addr && bus_wdata[15:8] == CNT_KEY;
  assign ovf_evt = tme && tick && cnt == 8'hFF && !cnt_hit;

  assign bus_rdata = bus_addr ? cnt : {ovf, wd, tme, 2'b11, cks};
  assign irq       = ovf && !wd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= 8'h00;
    else if (!tme)     cnt <= 8'h00;
    else if (cnt_hit)  cnt <= bus_wdata[7:0];
    else if (tick)     cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf <= 1'b0; wd <= 1'b0; tme <= 1'b0; cks <= 3'd0; armed <= 1'b0; reset_req <= 1'b0;
    end else begin
      reset_req <= ovf_evt && wd && !standby;
      if (standby) begin
        ovf <= 1'b0; wd <= 1'b0; tme <= 1'b0; armed <= 1'b0;
      end else begin
        if (ovf_evt)                                   ovf <= 1'b1;
        else if (csr_hit && armed && !bus_wdata[7])    ovf <= 1'b0;
        if (csr_hit) begin
          wd    <= bus_wdata[6];
          tme   <= bus_wdata[5];
          cks   <= bus_wdata[2:0];
          armed <= 1'b0;
        end else if (bus_rd && !bus_addr && ovf) begin
          armed <= 1'b1;
        end
      end
    end

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tme && tick && cnt == 8'hFF && !cnt_hit && !standby) |=> ovf);
  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(standby || (csr_hit && armed)));
  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R9
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !reset_req);
  // R6
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tme |=> cnt == 8'h00);
  // R2
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_wide && !standby && !csr_hit) |=> $stable({wd, tme, cks}));
endmodule

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic bus_addr = 1'b0, bus_we = 1'b0, bus_wide = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0] bus_rdata;
  logic reset_req, irq;

  int errors = 0, checks = 0;
  int pulses = 0, run = 0, max_run = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wdt_timer dut (.clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wide(bus_wide), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reset_req(reset_req), .irq(irq));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic wide, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = wide; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial forever begin
    @(negedge clk); #1;
    if (bus_rd && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    if (reset_req) begin run++; if (run == 1) pulses++; if (run > max_run) max_run = run; end
    else run = 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset_req", {7'd0, reset_req}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    rd(1'b0, 8'h18, "R1 csr reset");
    rd(1'b1, 8'h00, "R1 cnt reset");
    wr(1'b0, 1'b0, 16'hA527);
    rd(1'b0, 8'h18, "R2 byte write ignored");
    wr(1'b0, 1'b1, 16'hA427);
    rd(1'b0, 8'h18, "R2 wrong key ignored");
    wr(1'b0, 1'b1, 16'hA527);
    rd(1'b0, 8'h3F, "R2 R3 valid write");
    wr(1'b1, 1'b1, 16'h5A10);
    rd(1'b1, 8'h10, "R4 counter load");
    wr(1'b1, 1'b0, 16'h5A55);
    rd(1'b1, 8'h10, "R4 byte write ignored");
    wr(1'b1, 1'b1, 16'hA555);
    rd(1'b1, 8'h10, "R4 wrong key ignored");
    wr(1'b0, 1'b1, 16'hA507);
    rd(1'b1, 8'h00, "R6 disable clears counter");
    rd(1'b0, 8'h1F, "R6 R3 csr after disable");

    wr(1'b0, 1'b1, 16'hA521);
    repeat (320) @(posedge clk);
    rd(1'b1, 8'd10, "R5 div32 rate");
    wr(1'b0, 1'b1, 16'hA503);
    wr(1'b0, 1'b1, 16'hA523);
    repeat (1280) @(posedge clk);
    rd(1'b1, 8'd10, "R5 div128 rate");

    wr(1'b0, 1'b1, 16'hA500);
    wr(1'b0, 1'b1, 16'hA520);
    wr(1'b1, 1'b1, 16'h5AFD);
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    check("R9 irq on overflow", {7'd0, irq}, 8'h01);
    wr(1'b0, 1'b1, 16'hA520);
    rd(1'b0, 8'hB8, "R7 R8 clear without read kept");
    wr(1'b0, 1'b1, 16'hA5A0);
    rd(1'b0, 8'hB8, "R8 write one kept");
    wr(1'b0, 1'b1, 16'hA520);
    rd(1'b0, 8'h38, "R8 read then clear");
    check("R9 irq follows flag", {7'd0, irq}, 8'h00);
    check("R9 no reset pulse", pulses[7:0], 8'h00);

    wr(1'b0, 1'b1, 16'hA562);
    wr(1'b1, 1'b1, 16'h5AFE);
    for (int i = 0; i < 400 && pulses == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R10 one pulse", pulses[7:0], 8'h01);
    check("R10 pulse width", max_run[7:0], 8'h01);
    check("R10 irq low", {7'd0, irq}, 8'h00);
    rd(1'b0, 8'hFA, "R10 R7 flag in watchdog");

    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    repeat (2) @(negedge clk);
    rd(1'b0, 8'h1A, "R11 standby keeps clock select");
    rd(1'b1, 8'h00, "R11 counter cleared");

    wr(1'b0, 1'b1, 16'hA527);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, 8'h18, "R1 csr after reset");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule